// File: doc/BRIEF.md
# SD 4-bit Data Block Receiver

This block takes in a single data block that a card sends on a four-line SD data bus. Once the block is armed, it watches the lowest data line for a start bit. It then builds bytes from pairs of nibbles and hands each byte out with a one-cycle strobe. While the data arrives, it runs a separate CRC16 on every line. After the payload it collects the 16 check bits that each line carries, samples the end bit and reports whether any line's checksum disagreed. If no start bit appears within a bounded number of samples, the block reports a timeout.

Each rising edge of `clk` is one bus clock, and `dat_in` is sampled on every edge. The controlling logic pulses `start` once per expected block. It then consumes `byte_out` whenever `byte_valid` is high, and it reads `done`, `crc_err` and `timeout` at the end.

The state machine has five states:
- `ST_IDLE`: not armed.
- `ST_WAIT`: looking for the start bit.
- `ST_DATA`: receiving payload nibbles.
- `ST_CRCR`: receiving the check bits.
- `ST_ENDB`: sampling the end bit.

The transitions are:
- `ST_IDLE` moves to `ST_WAIT` on `start`.
- `ST_WAIT` moves to `ST_DATA` when the lowest line is low.
- `ST_WAIT` moves to `ST_IDLE` on timeout.
- `ST_DATA` moves to `ST_CRCR` after the last nibble.
- `ST_CRCR` moves to `ST_ENDB` after the sixteenth check bit.
- `ST_ENDB` moves to `ST_IDLE` unconditionally.

Top module: `sd4_block_rx`

## Requirements
- R1: After reset the block is idle, and `byte_valid`, `done`, `crc_err`, `timeout` and `byte_out` are all zero.
- R2: When `start` is high in idle, the block is armed. The first sample with `dat_in[0]` low is the start bit, and that sample carries no payload.
- R3: After the start bit, each byte takes two samples, high nibble first. `dat_in[3]` is bit 3 of a nibble and `dat_in[0]` is bit 0. `byte_out` is updated and `byte_valid` is high for exactly one cycle after the edge that sampled the low nibble. Exactly BLOCK_BYTES (default 512) bytes are produced.
- R4: Line n carries bit n+4 and then bit n of every byte. For each line the block computes a CRC16 over that line's serial bits, using polynomial 0x1021 and an initial value of 0.
- R5: After the payload, each line carries 16 check bits, most significant first, followed by one end bit whose value is ignored. `done` rises in the cycle after the end bit is sampled and stays high until the next accepted `start`.
- R6: `crc_err` is set together with `done` when at least one line's computed CRC differs from the check bits received on that line. A mismatch on any single line is enough on its own.
- R7: If TIMEOUT_CYCLES consecutive samples after arming all have `dat_in[0]` high, `timeout` is set, `done` stays low and the block returns to idle. A start bit on sample number TIMEOUT_CYCLES is still accepted.
- R8: `start` has no effect while a block is in progress, and the byte stream and the `done` timing are unchanged.
- R9: An accepted `start` clears `done`, `crc_err` and `timeout`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; one data sample per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Arms reception of one block |
| dat_in | input | 4 | The four SD data lines |
| byte_out | output | 8 | Last assembled byte |
| byte_valid | output | 1 | One-cycle strobe per new byte |
| done | output | 1 | Block finished after end bit |
| crc_err | output | 1 | At least one line CRC mismatched |
| timeout | output | 1 | Start bit not seen in time |

## Verification
If the nibble counter has a bad value, it shows up at the ports within one block. The strobes come out misplaced, the byte count differs from the block length, or `done` rises on the wrong cycle, so the bench checks the strobe count and the exact cycle of `done`. If one line's CRC register is wrong, the only symptom is the `crc_err` flag at the end of the block. For that reason the bench corrupts each line in turn, and it also runs clean blocks with several data patterns whose expected checksums it computes itself. Timeout counting is checked one sample before and on the limit, so a counter that is off by one is seen at that exact cycle.

// File: rtl/sd4rx_pkg.sv
package sd4rx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_WAIT = 3'd1,
        ST_DATA = 3'd2,
        ST_CRCR = 3'd3,
        ST_ENDB = 3'd4
    } rx_state_t;

    localparam int unsigned LANES   = 4;
    localparam logic [15:0] CRC_POLY = 16'h1021;
endpackage

// File: rtl/sd4rx_lane_crc.sv
// One data line: running CRC16 over payload bits plus capture of the
// check bits sent on the same line.
module sd4rx_lane_crc #(
    parameter int CRC_W = 16,
    parameter logic [CRC_W-1:0] POLY = 16'h1021
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic calc_en,
    input  logic cap_en,
    input  logic bit_in,
    output logic match
);
    logic [CRC_W-1:0] calc_q;
    logic [CRC_W-1:0] recv_q;
    logic             feedback;

    assign feedback = calc_q[CRC_W-1] ^ bit_in;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            calc_q <= '0;
            recv_q <= '0;
        end else if (clear) begin
            calc_q <= '0;
            recv_q <= '0;
        end else begin
            if (calc_en) begin
                calc_q <= {calc_q[CRC_W-2:0], 1'b0} ^ (feedback ? POLY : '0);
            end
            if (cap_en) begin
                recv_q <= {recv_q[CRC_W-2:0], bit_in};
            end
        end
    end

    assign match = (calc_q == recv_q);
endmodule

// File: rtl/sd4rx_counter.sv
// Shared phase counter: restarts on every state change.
module sd4rx_counter #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    output logic [W-1:0] value
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value <= '0;
        end else if (restart) begin
            value <= '0;
        end else begin
            value <= value + 1'b1;
        end
    end
endmodule

// File: rtl/sd4_block_rx.sv
module sd4_block_rx
    import sd4rx_pkg::*;
#(
    parameter int BLOCK_BYTES    = 512,
    parameter int CRC_BITS       = 16,
    parameter int TIMEOUT_CYCLES = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [3:0] dat_in,
    output logic [7:0] byte_out,
    output logic       byte_valid,
    output logic       done,
    output logic       crc_err,
    output logic       timeout
);
    localparam int NIBBLES = 2 * BLOCK_BYTES;
    localparam int CNT_MAX = (NIBBLES > TIMEOUT_CYCLES) ?
                             ((NIBBLES > CRC_BITS) ? NIBBLES : CRC_BITS) :
                             ((TIMEOUT_CYCLES > CRC_BITS) ? TIMEOUT_CYCLES : CRC_BITS);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    rx_state_t        state_q, state_d;
    logic [CNT_W-1:0] cnt;
    logic             last_nib, last_crc, last_wait;
    logic [3:0]       hi_nib_q;
    logic [LANES-1:0] lane_ok;
    logic             arm;

    assign arm       = (state_q == ST_IDLE) && start;
    assign last_nib  = (cnt == CNT_W'(NIBBLES - 1));
    assign last_crc  = (cnt == CNT_W'(CRC_BITS - 1));
    assign last_wait = (cnt == CNT_W'(TIMEOUT_CYCLES - 1));

    sd4rx_counter #(.W(CNT_W)) phase_cnt_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (state_q != state_d),
        .value   (cnt)
    );

    for (genvar ln = 0; ln < LANES; ln++) begin : g_lane
        sd4rx_lane_crc #(.CRC_W(CRC_BITS), .POLY(CRC_BITS'(CRC_POLY))) lane_i (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear   (arm),
            .calc_en (state_q == ST_DATA),
            .cap_en  (state_q == ST_CRCR),
            .bit_in  (dat_in[ln]),
            .match   (lane_ok[ln])
        );
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_WAIT;
            ST_WAIT: begin
                if (!dat_in[0])     state_d = ST_DATA;
                else if (last_wait) state_d = ST_IDLE;
            end
            ST_DATA: if (last_nib) state_d = ST_CRCR;
            ST_CRCR: if (last_crc) state_d = ST_ENDB;
            ST_ENDB: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            byte_out   <= '0;
            byte_valid <= 1'b0;
            done       <= 1'b0;
            crc_err    <= 1'b0;
            timeout    <= 1'b0;
            hi_nib_q   <= '0;
        end else begin
            byte_valid <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        done    <= 1'b0;
                        crc_err <= 1'b0;
                        timeout <= 1'b0;
                    end
                end
                ST_WAIT: begin
                    if (dat_in[0] && last_wait) timeout <= 1'b1;
                end
                ST_DATA: begin
                    if (!cnt[0]) begin
                        hi_nib_q <= dat_in;
                    end else begin
                        byte_out   <= {hi_nib_q, dat_in};
                        byte_valid <= 1'b1;
                    end
                end
                ST_CRCR: ;
                ST_ENDB: begin
                    done    <= 1'b1;
                    crc_err <= ~(&lane_ok);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sd4rx_checker.sv
module sd4rx_checker
    import sd4rx_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      byte_valid,
    input logic      done,
    input logic      crc_err,
    input logic      timeout,
    input rx_state_t state_q
);
    a_r3_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> !byte_valid);

    a_r3_no_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> !byte_valid);

    a_r5_done_after_end: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(state_q == ST_ENDB));

    a_r7_timeout_from_wait: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout) |-> $past(state_q == ST_WAIT));

    a_r7_timeout_no_done: assert property (@(posedge clk) disable iff (!rst_n)
        timeout |-> !done);

    a_r6_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_err) |-> $rose(done));
endmodule

bind sd4_block_rx sd4rx_checker chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .byte_valid (byte_valid),
    .done       (done),
    .crc_err    (crc_err),
    .timeout    (timeout),
    .state_q    (state_q)
);

// File: tb/sd4_block_rx_tb.sv
module sd4_block_rx_tb_top;
    localparam int BYTES = 512;
    localparam int TO    = 256;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [3:0] dat_in = 4'hF;
    logic [7:0] byte_out;
    logic       byte_valid, done, crc_err, timeout;

    int checks = 0;
    int errors = 0;
    int rx_idx = 0;
    int bad_bytes = 0;
    logic [7:0] exp_mem [BYTES];

    always #2.5 clk = ~clk;

    sd4_block_rx #(.BLOCK_BYTES(BYTES), .CRC_BITS(16), .TIMEOUT_CYCLES(TO)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .dat_in(dat_in),
        .byte_out(byte_out), .byte_valid(byte_valid), .done(done),
        .crc_err(crc_err), .timeout(timeout)
    );

    always @(negedge clk) begin
        if (byte_valid) begin
            if (rx_idx >= BYTES || byte_out !== exp_mem[rx_idx]) bad_bytes++;
            rx_idx++;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat_byte(input int pat, input int i);
        case (pat)
            0: return 8'(i);
            1: return 8'h00;
            2: return 8'hFF;
            3: return 8'((i * 37 + 11) ^ (i >> 3));
            default: return {4'(i), ~4'(i >> 4)};
        endcase
    endfunction

    function automatic logic [15:0] crc_step(input logic [15:0] c, input logic b);
        logic fb;
        fb = c[15] ^ b;
        return {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
    endfunction

    // bad_lane < 0: clean block; poke_nib >= 0: pulse start at that nibble
    task automatic run_block(input int pat, input int delay, input int bad_lane,
                             input int poke_nib, input string tag);
        logic [15:0] crc [4];
        for (int n = 0; n < 4; n++) crc[n] = 16'h0;
        for (int i = 0; i < BYTES; i++) begin
            exp_mem[i] = pat_byte(pat, i);
            for (int n = 0; n < 4; n++) begin
                crc[n] = crc_step(crc[n], exp_mem[i][n+4]);
                crc[n] = crc_step(crc[n], exp_mem[i][n]);
            end
        end
        rx_idx = 0;
        bad_bytes = 0;
        @(negedge clk); start = 1'b1; dat_in = 4'hF;
        @(negedge clk); start = 1'b0;
        chk({tag, " R9 flags cleared"}, {done, crc_err, timeout}, 3'b000);
        for (int d = 0; d < delay; d++) begin dat_in = 4'hF; @(negedge clk); end
        dat_in = 4'hE; @(negedge clk);
        for (int k = 0; k < 2 * BYTES; k++) begin
            start  = (k == poke_nib);
            dat_in = (k % 2 == 0) ? exp_mem[k/2][7:4] : exp_mem[k/2][3:0];
            @(negedge clk);
        end
        start = 1'b0;
        for (int b = 0; b < 16; b++) begin
            for (int n = 0; n < 4; n++)
                dat_in[n] = crc[n][15-b] ^ ((b == 0) && (n == bad_lane));
            @(negedge clk);
        end
        dat_in = 4'h0; // end bit value ignored
        chk({tag, " R5 done low before end bit"}, done, 1'b0);
        @(negedge clk);
        dat_in = 4'hF;
        chk({tag, " R5 done after end bit"}, done, 1'b1);
        chk({tag, " R6 crc_err"}, crc_err, (bad_lane >= 0));
        chk({tag, " R3 byte count"}, rx_idx, BYTES);
        chk({tag, " R3 R4 byte values"}, bad_bytes, 0);
        repeat (3) @(negedge clk);
        chk({tag, " R5 done held"}, done, 1'b1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset outputs", {byte_out, byte_valid, done, crc_err, timeout}, 12'h0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle no strobe", byte_valid, 1'b0);
        // R2 R3 R4: several patterns and start-bit delays
        run_block(0, 0,  -1, -1, "ramp");
        run_block(1, 3,  -1, -1, "zeros");
        run_block(2, 7,  -1, -1, "ones");
        run_block(3, 1,  -1, -1, "mix");
        run_block(4, 20, -1, -1, "nibswap");
        // R6: each lane corrupted alone
        for (int ln = 0; ln < 4; ln++) run_block(3, 2, ln, -1, $sformatf("lane%0d", ln));
        // R8: start pulses mid-block
        run_block(0, 0, -1, 301, "poke");
        // R7 boundary: start bit on the last allowed sample
        run_block(3, TO - 1, -1, -1, "edge");
        // R7 timeout
        @(negedge clk); start = 1'b1; dat_in = 4'hF;
        @(negedge clk); start = 1'b0;
        repeat (TO - 1) @(negedge clk);
        chk("R7 no timeout before limit", timeout, 1'b0);
        @(negedge clk);
        chk("R7 timeout at limit", timeout, 1'b1);
        chk("R7 no done on timeout", done, 1'b0);
        dat_in = 4'hE; repeat (4) @(negedge clk); dat_in = 4'hF;
        chk("R7 idle after timeout no strobe", rx_idx, 512);
        // R9: new block clears timeout
        run_block(1, 0, -1, -1, "after_to");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule